// File: doc/BRIEF.md
# Disk Controller Command and Status Unit

This block sits between the processor's I/O instruction path and the transfer engine of a head-per-track disk controller. Every I/O instruction arrives as a one-cycle strobe with a 6-bit operation field and a flag that picks one of two device codes. Bits 5:4 of the field select a sub-command, and bits 2:0 are three pulse bits that act in order: bit 0, then bit 1, then bit 2.

The block holds the 18-bit function and status word, the 21-bit disk address and an 18-bit data buffer. It returns read data and a skip request in the same cycle as the strobe. It also raises a start strobe for the transfer engine and a clear strobe that cancels a running transfer. It drives an interrupt request.

The transfer engine reports errors and completion through an update port, which ORs flags into bits 16:7. The engine's busy input guards the registers. A command that would change or read a register while the engine is busy only records a programming error.

Top module: `dskctl_cmd`

## Requirements
- R1: The status word reads bits 6:3 as zero. Bit 17 (error summary) equals the OR of bits 16:10. Bits 9 (channel timing) and 8 (programming error) are not included in the summary.
- R2: `irq` is high exactly when bit 0 (interrupt enable) is set and bit 17 or bit 7 (done) is set.
- R3: On the primary code, pulse bit 0 with sub-command 0 drives `skip` high in that cycle when bit 17 or bit 7 is set. Otherwise `skip` is low.
- R4: On the primary code, pulse bit 0 with sub-command 1 clears the status, the disk address and the data buffer, and pulses `clr_xfer` in that cycle.
- R5: On the primary code, pulse bit 0 with sub-command 2 clears bits 2:0 when idle. When busy it sets bit 8 and leaves bits 2:0 unchanged.
- R6: On the primary code, a pulse bit 1 or pulse bit 2 command issued while `busy` is high sets bit 8 and does nothing else. No register loads, `dout` stays zero and `start` stays low.
- R7: On the primary code, pulse bit 1 with sub-command 2 XORs `din[2:0]` into bits 2:0. Bits 2:1 are the function (0 none, 1 read, 2 write, 3 check) and bit 0 is interrupt enable.
- R8: On the primary code, pulse bit 2 with sub-command 1 loads address bits 17:0 from `din`, and pulse bit 2 with sub-command 3 loads address bits 20:18 from `din[2:0]`. Pulse bit 1 with sub-command 1 reads the low part. Pulse bit 1 with sub-command 3 reads the high part in `dout[2:0]`, with `dout[3]` set when bit 10 (nonexistent disk) is set.
- R9: On the primary code, pulse bit 2 with sub-command 0 loads the data buffer, and pulse bit 1 with sub-command 0 reads it on `dout`.
- R10: On the primary code, pulse bit 2 with sub-command 2 clears bit 7. It pulses `start` only when bits 2:1 are nonzero.
- R11: On the secondary code, pulse bit 1 with sub-command 2 clears every status bit except 2:0 when idle. When busy it sets bit 8 instead.
- R12: On the secondary code, pulse bit 1 with sub-command 3 returns the status word on `dout`. When busy it sets bit 8, and the returned word already shows bit 8.
- R13: On the secondary code, pulse bit 1 with sub-command 0 returns `rot_pos` in the low bits and `busy` in bit 17.
- R14: `upd_flags` ORs into status bits 16:7 after any command in the same cycle, and its other bits are ignored. A low `rst_n` at a clock edge clears all registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iot_valid | input | 1 | I/O instruction strobe |
| iot_sec | input | 1 | Selects the secondary device code |
| iot_op | input | 6 | Sub-command in bits 5:4, pulse bits in bits 2:0 |
| din | input | 18 | Data from the processor |
| busy | input | 1 | Transfer engine is active |
| rot_pos | input | 11 | Current rotational word position |
| upd_valid | input | 1 | Flag update from the transfer engine |
| upd_flags | input | 18 | Flags to OR into status bits 16:7 |
| dout | output | 18 | Read data, same cycle as the strobe |
| skip | output | 1 | Skip request |
| start | output | 1 | Start a transfer |
| clr_xfer | output | 1 | Cancel any active transfer |
| irq | output | 1 | Interrupt request |
| status | output | 18 | Function and status word |
| disk_addr | output | 21 | Disk address |

## Verification
A corrupted status bit shows up on `status` at the next edge. It also shows up in `irq` and `skip` at once, because both are decoded from the stored word with no further register. A wrong address or buffer value is hidden until a read command returns it on `dout` in the strobe cycle, so the bench reads back every load. A wrong busy guard shows at the edge after the command, either as a missing bit 8 or as a register that changed when it should not have.

// File: rtl/dskctl_cmd.sv
module dskctl_cmd #(
  parameter int DW = 18,
  parameter int AW = 21,
  parameter int PW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iot_valid,
  input  logic          iot_sec,
  input  logic [5:0]    iot_op,
  input  logic [DW-1:0] din,
  input  logic          busy,
  input  logic [PW-1:0] rot_pos,
  input  logic          upd_valid,
  input  logic [DW-1:0] upd_flags,
  output logic [DW-1:0] dout,
  output logic          skip,
  output logic          start,
  output logic          clr_xfer,
  output logic          irq,
  output logic [DW-1:0] status,
  output logic [AW-1:0] disk_addr
);
  localparam int ERR = DW - 1;
  localparam int NED = 10;
  localparam int PGE = 8;
  localparam int DON = 7;
  localparam int HW  = AW - DW;
  localparam logic [DW-1:0] UPD_MASK = {1'b0, {(DW-1-DON){1'b1}}, {DON{1'b0}}};
  localparam logic [DW-1:0] FN_MASK  = DW'(7);

  logic [DW-1:0] sta_q, sta_d, buf_q, buf_d;
  logic [AW-1:0] da_q, da_d;
  logic [1:0]    sb;

  assign sb        = iot_op[5:4];
  assign status    = sta_q;
  assign disk_addr = da_q;
  assign irq       = sta_q[0] & (sta_q[ERR] | sta_q[DON]);

  function automatic logic [DW-1:0] tidy(input logic [DW-1:0] s);
    logic [DW-1:0] r;
    r = s;
    r[6:3] = '0;
    r[ERR] = |s[ERR-1:NED];
    return r;
  endfunction

  always_comb begin
    sta_d = sta_q;
    da_d  = da_q;
    buf_d = buf_q;
    dout  = '0;
    skip  = 1'b0;
    start = 1'b0;
    clr_xfer = 1'b0;
    if (iot_valid) begin
      if (!iot_sec) begin
        if (iot_op[0]) begin
          case (sb)
            2'd0: skip = sta_q[ERR] | sta_q[DON];
            2'd1: begin
              sta_d = '0; da_d = '0; buf_d = '0; clr_xfer = 1'b1;
            end
            2'd2: if (busy) sta_d[PGE] = 1'b1; else sta_d = sta_d & ~FN_MASK;
            default: ;
          endcase
        end
        if (iot_op[1]) begin
          if (busy) sta_d[PGE] = 1'b1;
          else case (sb)
            2'd0: dout = buf_d;
            2'd1: dout = da_d[DW-1:0];
            2'd2: sta_d = sta_d ^ (din & FN_MASK);
            default: dout = DW'(da_d[AW-1:DW]) | (sta_d[NED] ? DW'(8) : '0);
          endcase
        end
        if (iot_op[2]) begin
          if (busy) sta_d[PGE] = 1'b1;
          else case (sb)
            2'd0: buf_d = din;
            2'd1: da_d[DW-1:0] = din;
            2'd2: begin
              sta_d[DON] = 1'b0;
              start = sta_d[2:1] != 2'd0;
            end
            default: da_d[AW-1:DW] = din[HW-1:0];
          endcase
        end
      end else if (iot_op[1]) begin
        case (sb)
          2'd0: dout = {busy, {(DW-1-PW){1'b0}}, rot_pos};
          2'd2: if (busy) sta_d[PGE] = 1'b1; else sta_d = sta_d & FN_MASK;
          2'd3: begin
            if (busy) sta_d[PGE] = 1'b1;
            dout = tidy(sta_d);
          end
          default: ;
        endcase
      end
    end
    if (upd_valid) sta_d = sta_d | (upd_flags & UPD_MASK);
    sta_d = tidy(sta_d);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_q <= '0;
      da_q  <= '0;
      buf_q <= '0;
    end else begin
      sta_q <= sta_d;
      da_q  <= da_d;
      buf_q <= buf_d;
    end
  end
endmodule

module dskctl_cmd_chk #(
  parameter int DW = 18,
  parameter int AW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iot_valid,
  input logic          iot_sec,
  input logic [5:0]    iot_op,
  input logic          busy,
  input logic          upd_valid,
  input logic [DW-1:0] upd_flags,
  input logic          skip,
  input logic          start,
  input logic          clr_xfer,
  input logic          irq,
  input logic [DW-1:0] status,
  input logic [AW-1:0] disk_addr
);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status[6:3] == 4'd0);
  p_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (status[0] & (status[DW-1] | status[7])));
  p_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (status[DW-1] | status[7]));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_xfer |=> (disk_addr == '0 && status[2:0] == 3'd0));
  p_busy_pge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iot_valid && !iot_sec && (iot_op[1] || iot_op[2]) && busy) |=> status[8]);
  p_busy_nostart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
  p_start_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !(upd_valid && upd_flags[7])) |=> !status[7]);
  p_start_fn_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (status[2:1] != 2'd0));
endmodule

bind dskctl_cmd dskctl_cmd_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iot_valid(iot_valid), .iot_sec(iot_sec),
  .iot_op(iot_op), .busy(busy), .upd_valid(upd_valid), .upd_flags(upd_flags),
  .skip(skip), .start(start), .clr_xfer(clr_xfer), .irq(irq),
  .status(status), .disk_addr(disk_addr)
);

// File: tb/dskctl_cmd_test.sv
module dskctl_cmd_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic iot_valid = 1'b0, iot_sec = 1'b0, busy = 1'b0, upd_valid = 1'b0;
  logic [5:0] iot_op = '0;
  logic [17:0] din = '0, upd_flags = '0;
  logic [10:0] rot_pos = 11'o1234;
  logic [17:0] dout, status;
  logic skip, start, clr_xfer, irq;
  logic [20:0] disk_addr;
  int checks = 0, fails = 0;
  logic [17:0] c_dout;
  logic c_skip, c_start, c_clr;

  always #2.5 clk = ~clk;

  dskctl_cmd uut (.clk, .rst_n, .iot_valid, .iot_sec, .iot_op, .din, .busy,
    .rot_pos, .upd_valid, .upd_flags, .dout, .skip, .start, .clr_xfer, .irq,
    .status, .disk_addr);

  // sec, op, din, busy, expected dout, expected status after, expected start
  localparam int NV = 22;
  localparam logic [62:0] VEC [NV] = '{
    {1'b0, 6'o04, 18'o123456, 1'b0, 18'o0,      18'o0,   1'b0}, // R9 load buffer
    {1'b0, 6'o02, 18'o0,      1'b0, 18'o123456, 18'o0,   1'b0}, // R9 read buffer
    {1'b0, 6'o24, 18'o765432, 1'b0, 18'o0,      18'o0,   1'b0}, // R8 addr low
    {1'b0, 6'o64, 18'o5,      1'b0, 18'o0,      18'o0,   1'b0}, // R8 addr high
    {1'b0, 6'o22, 18'o0,      1'b0, 18'o765432, 18'o0,   1'b0}, // R8
    {1'b0, 6'o62, 18'o0,      1'b0, 18'o5,      18'o0,   1'b0}, // R8
    {1'b0, 6'o42, 18'o3,      1'b0, 18'o0,      18'o3,   1'b0}, // R7 xor
    {1'b0, 6'o42, 18'o6,      1'b0, 18'o0,      18'o5,   1'b0}, // R7 xor
    {1'b0, 6'o44, 18'o0,      1'b0, 18'o0,      18'o5,   1'b1}, // R10 start
    {1'b0, 6'o04, 18'o7,      1'b1, 18'o0,      18'o405, 1'b0}, // R6 busy load
    {1'b0, 6'o02, 18'o0,      1'b1, 18'o0,      18'o405, 1'b0}, // R6 busy read
    {1'b1, 6'o62, 18'o0,      1'b0, 18'o405,    18'o405, 1'b0}, // R12
    {1'b1, 6'o42, 18'o0,      1'b0, 18'o0,      18'o5,   1'b0}, // R11
    {1'b0, 6'o41, 18'o0,      1'b0, 18'o0,      18'o0,   1'b0}, // R5
    {1'b0, 6'o42, 18'o777777, 1'b0, 18'o0,      18'o7,   1'b0}, // R7 only 2:0
    {1'b0, 6'o42, 18'o1,      1'b1, 18'o0,      18'o407, 1'b0}, // R6 busy xor
    {1'b1, 6'o02, 18'o0,      1'b1, 18'o401234, 18'o407, 1'b0}, // R13
    {1'b1, 6'o42, 18'o0,      1'b1, 18'o0,      18'o407, 1'b0}, // R11 busy
    {1'b0, 6'o21, 18'o0,      1'b0, 18'o0,      18'o0,   1'b0}, // R4
    {1'b0, 6'o44, 18'o0,      1'b0, 18'o0,      18'o0,   1'b0}, // R10 no start
    {1'b0, 6'o02, 18'o0,      1'b0, 18'o0,      18'o0,   1'b0}, // R4 buffer
    {1'b0, 6'o22, 18'o0,      1'b0, 18'o0,      18'o0,   1'b0}  // R4 address
  };

  task automatic chk(input string req, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0o expected %0o", req, act, exp);
    end
  endtask

  task automatic go(input logic s, input logic [5:0] op, input logic [17:0] d, input logic b);
    @(negedge clk);
    iot_valid = 1'b1; iot_sec = s; iot_op = op; din = d; busy = b;
    #1;
    c_dout = dout; c_skip = skip; c_start = start; c_clr = clr_xfer;
    @(posedge clk); #1;
    iot_valid = 1'b0; busy = 1'b0;
  endtask

  task automatic upd(input logic [17:0] f);
    @(negedge clk);
    upd_valid = 1'b1; upd_flags = f;
    @(posedge clk); #1;
    upd_valid = 1'b0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R14 reset status", status, 0);
    chk("R14 reset addr", disk_addr, 0);
    chk("R2 reset irq", irq, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      go(VEC[i][62], VEC[i][61:56], VEC[i][55:38], VEC[i][37]);
      chk($sformatf("R6-R13 vec%0d dout", i), c_dout, VEC[i][36:19]);
      chk($sformatf("R5-R13 vec%0d status", i), status, VEC[i][18:1]);
      chk($sformatf("R10 vec%0d start", i), c_start, VEC[i][0]);
    end
    upd(18'o001170);
    chk("R14 R1 channel flag only", status, 18'o001000);
    go(0, 6'o42, 18'o1, 0);
    chk("R2 ie without cause", irq, 0);
    upd(18'o000200);
    chk("R14 done set", status, 18'o001201);
    chk("R2 irq on done", irq, 1);
    go(0, 6'o01, 0, 0);
    chk("R3 skip on done", c_skip, 1);
    go(0, 6'o44, 0, 0);
    chk("R10 start clears done", status, 18'o001001);
    chk("R10 no start for no-op", c_start, 0);
    go(0, 6'o01, 0, 0);
    chk("R3 no skip", c_skip, 0);
    upd(18'o002000);
    chk("R1 summary from nxd", status, 18'o403001);
    chk("R2 irq on error", irq, 1);
    go(0, 6'o62, 0, 0);
    chk("R8 high read nxd bit", c_dout, 18'o10);
    go(0, 6'o01, 0, 0);
    chk("R3 skip on error", c_skip, 1);
    go(1, 6'o42, 0, 0);
    chk("R11 clear keeps fn", status, 18'o1);
    chk("R2 irq dropped", irq, 0);
    go(0, 6'o64, 18'o3, 0);
    go(0, 6'o21, 0, 0);
    chk("R4 clear strobe", c_clr, 1);
    chk("R4 addr cleared", disk_addr, 0);
    go(0, 6'o42, 18'o1, 0);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R14 sync reset", status, 0);
    rst_n = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule